// File: doc/BRIEF.md
# DMA Channel Control Sequencer

This block holds the 8-bit control register of one DMA channel and runs the state machine that starts, chains, completes and aborts its block transfers. Software writes the control byte to arm the channel, request a transfer, choose repeat and one-shot behaviour and issue a channel reset. A separate port loads a repeat count. The sequencer drives a small transfer-engine handshake. It raises a one-cycle block-start pulse, and a last-block flag with that pulse. It waits for the engine's block-done strobe. On a disable it waits for the engine's buffer-empty signal before it pulses abort.

Several control bits clear themselves at fixed protocol points. A software disable takes effect in the register at once, but the busy flag stays set until the buffer has drained. A channel reset is accepted only while the channel is idle. Address generation, bus traffic and trigger selection belong to the engine and lie outside this block.

Control byte layout, MSB first: bit 7 enable, bit 6 channel reset, bit 5 repeat, bit 4 transfer request, bit 3 reserved, bit 2 single, bits 1:0 burst length.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset the control byte, the repeat count, busy, blk_start and blk_abort are all 0. Bit 3 of ctl_rdata always reads 0, and whatever is written to bit 3 is discarded. Bits 7, 5, 2 and 1:0 read back the last value written to them, unless hardware has cleared them since.
- R2: A write to the transfer-request bit (bit 4) is stored only when the same write sets the enable bit (bit 7). Otherwise bit 4 becomes 0.
- R3: When the channel is idle, and enable and transfer request are both 1 with the reset bit at 0, blk_start is high for one cycle. At the next edge busy goes to 1 and the transfer-request bit clears.
- R4: A blk_done during the last block clears the enable bit. busy is 0 in the following cycle.
- R5: Each block start decrements a nonzero repeat count by one. With repeat set, the block started at count 1 is the last one. The repeat bit clears at that start, and blk_last is high together with blk_start.
- R6: With repeat set and a count of 0, blocks continue without limit. blk_last stays 0, the count stays 0 and the repeat bit stays 1.
- R7: With single at 0, the next block starts in the cycle after blk_done. With single at 1, the channel waits, busy, until a new transfer request is written.
- R8: Writing enable to 0 while busy makes bit 7 read 0 at once. busy stays 1 until buf_empty is seen. blk_abort then pulses for one cycle, and busy is 0 in the cycle after.
- R9: A write of 1 to the reset bit is ignored while busy. When it is accepted, bit 6 reads 1 for one cycle. The next edge returns the control byte and the repeat count to 0, and a control write made in that cycle is dropped.
- R10: With repeat at 0, exactly one block runs, and blk_last is high with its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read value |
| rep_wr | input | 1 | Repeat count write strobe |
| rep_wdata | input | REP_W | Repeat count write data |
| rep_rdata | output | REP_W | Current repeat count |
| busy | output | 1 | Channel busy flag |
| blk_start | output | 1 | One-cycle block start pulse to the engine |
| blk_last | output | 1 | Marks the started block as the final one |
| blk_done | input | 1 | Engine strobe: current block finished |
| buf_empty | input | 1 | Engine internal buffer is empty |
| blk_abort | output | 1 | One-cycle abort pulse to the engine |

## Verification
The assertions check these rules on every cycle:
- the transfer-request bit rises only together with enable;
- a channel reset is taken only when the channel was idle, and it zeroes every field one cycle later;
- the count steps down by one on each start;
- a start is followed by busy;
- completion and abort are followed by idle, and a drain holds until the buffer empties.

Only the bench's scenarios show which block is the last one for a given count and mode. The same holds for the automatic restart versus the wait for a new request, the unlimited repeat, and the full read-back of all 256 control bytes.

// File: rtl/dma_cc_pkg.sv
package dma_cc_pkg;

   localparam int unsigned CTL_W      = 8;
   localparam int unsigned BIT_EN     = 7;
   localparam int unsigned BIT_SRST   = 6;
   localparam int unsigned BIT_REP    = 5;
   localparam int unsigned BIT_TRQ    = 4;
   localparam int unsigned BIT_RSV    = 3;
   localparam int unsigned BIT_SINGLE = 2;
   localparam int unsigned BURST_W    = 2;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RUN   = 3'd1,
      ST_WAIT  = 3'd2,
      ST_DRAIN = 3'd3,
      ST_ABORT = 3'd4
   } seq_state_t;

   typedef struct packed {
      logic               en;
      logic               srst;
      logic               rep;
      logic               trq;
      logic               single;
      logic [BURST_W-1:0] burst;
   } ctl_fields_t;

endpackage

// File: rtl/dma_cc_ctlreg.sv
module dma_cc_ctlreg
   import dma_cc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [CTL_W-1:0] wdata_i,
   input  logic             busy_i,
   input  logic             hw_start_i,
   input  logic             hw_last_i,
   input  logic             hw_done_i,
   output ctl_fields_t      fields_o,
   output logic [CTL_W-1:0] rdata_o
);

   ctl_fields_t f_q, f_d;

   always_comb begin
      f_d = f_q;
      if (wr_i) begin
         f_d.en     = wdata_i[BIT_EN];
         f_d.srst   = wdata_i[BIT_SRST] & ~busy_i;
         f_d.rep    = wdata_i[BIT_REP];
         f_d.trq    = wdata_i[BIT_TRQ] & wdata_i[BIT_EN];
         f_d.single = wdata_i[BIT_SINGLE];
         f_d.burst  = wdata_i[BURST_W-1:0];
      end
      // hardware clears win over a coincident bus write
      if (hw_start_i) f_d.trq = 1'b0;
      if (hw_last_i)  f_d.rep = 1'b0;
      if (hw_done_i)  f_d.en  = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        f_q <= '0;
      else if (f_q.srst) f_q <= '0;
      else               f_q <= f_d;
   end

   assign fields_o = f_q;
   assign rdata_o  = {f_q.en, f_q.srst, f_q.rep, f_q.trq, 1'b0, f_q.single, f_q.burst};

   assert_trq_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_q.trq) |-> f_q.en);
   assert_srst_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(f_q.srst) |-> !$past(busy_i));
   assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      f_q.srst |=> (f_q == '0));

endmodule

// File: rtl/dma_cc_repcnt.sv
module dma_cc_repcnt #(
   parameter int unsigned REP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic [REP_W-1:0] wdata_i,
   input  logic             dec_i,
   output logic [REP_W-1:0] cnt_o,
   output logic             is_one_o
);

   localparam logic [REP_W-1:0] ONE = REP_W'(1);

   logic [REP_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt_q <= '0;
      else if (clr_i)                cnt_q <= '0;
      else if (wr_i)                 cnt_q <= wdata_i;
      else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - ONE;
   end

   assign cnt_o    = cnt_q;
   assign is_one_o = (cnt_q == ONE);

   assert_count_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !clr_i && !wr_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
   assert_count_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/dma_cc_seq.sv
module dma_cc_seq
   import dma_cc_pkg::*;
#(
   parameter bit LAST_HOLD = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   input  logic trq_i,
   input  logic rep_i,
   input  logic single_i,
   input  logic srst_i,
   input  logic cnt_one_i,
   input  logic blk_done_i,
   input  logic buf_empty_i,
   output logic start_o,
   output logic last_start_o,
   output logic complete_o,
   output logic busy_o,
   output logic abort_o,
   output logic last_o
);

   seq_state_t st_q, st_d;
   logic       last_q;
   logic       last_now;

   assign last_now = ~rep_i | cnt_one_i;

   always_comb begin
      st_d       = st_q;
      start_o    = 1'b0;
      complete_o = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (en_i && trq_i && !srst_i) begin
               start_o = 1'b1;
               st_d    = ST_RUN;
            end
         end
         ST_RUN: begin
            if (!en_i) st_d = ST_DRAIN;
            else if (blk_done_i) begin
               if (last_q) begin
                  complete_o = 1'b1;
                  st_d       = ST_IDLE;
               end else begin
                  st_d = ST_WAIT;
               end
            end
         end
         ST_WAIT: begin
            if (!en_i) st_d = ST_DRAIN;
            else if (!single_i || trq_i) begin
               start_o = 1'b1;
               st_d    = ST_RUN;
            end
         end
         ST_DRAIN: if (buf_empty_i) st_d = ST_ABORT;
         ST_ABORT: st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         last_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (start_o) last_q <= last_now;
      end
   end

   assign last_start_o = start_o & last_now;
   assign busy_o       = (st_q != ST_IDLE);
   assign abort_o      = (st_q == ST_ABORT);

   generate
      if (LAST_HOLD) begin : g_last_hold
         assign last_o = (st_q == ST_RUN) & last_q;
      end else begin : g_last_pulse
         assign last_o = last_start_o;
      end
   endgenerate

   assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |=> (busy_o && st_q == ST_RUN));
   assert_complete_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      complete_o |=> !busy_o);
   assert_abort_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |=> (!abort_o && !busy_o));
   assert_drain_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DRAIN && !buf_empty_i) |=> (st_q == ST_DRAIN));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
   import dma_cc_pkg::*;
#(
   parameter int unsigned REP_W     = 8,
   parameter bit          LAST_HOLD = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_wr,
   input  logic [7:0]       ctl_wdata,
   output logic [7:0]       ctl_rdata,
   input  logic             rep_wr,
   input  logic [REP_W-1:0] rep_wdata,
   output logic [REP_W-1:0] rep_rdata,
   output logic             busy,
   output logic             blk_start,
   output logic             blk_last,
   input  logic             blk_done,
   input  logic             buf_empty,
   output logic             blk_abort
);

   generate
      if (REP_W < 1 || REP_W > 16) begin : g_bad_rep_w
         $error("dma_chan_ctrl: REP_W must lie in 1..16");
      end
      if (CTL_W != 8) begin : g_bad_ctl_w
         $error("dma_chan_ctrl: control byte must be 8 bits");
      end
   endgenerate

   ctl_fields_t fields;
   logic        start, last_start, complete, cnt_one;

   dma_cc_ctlreg u_ctlreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (ctl_wr),
      .wdata_i    (ctl_wdata),
      .busy_i     (busy),
      .hw_start_i (start),
      .hw_last_i  (last_start),
      .hw_done_i  (complete),
      .fields_o   (fields),
      .rdata_o    (ctl_rdata)
   );

   dma_cc_repcnt #(.REP_W(REP_W)) u_repcnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr_i    (fields.srst),
      .wr_i     (rep_wr),
      .wdata_i  (rep_wdata),
      .dec_i    (start),
      .cnt_o    (rep_rdata),
      .is_one_o (cnt_one)
   );

   dma_cc_seq #(.LAST_HOLD(LAST_HOLD)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (fields.en),
      .trq_i        (fields.trq),
      .rep_i        (fields.rep),
      .single_i     (fields.single),
      .srst_i       (fields.srst),
      .cnt_one_i    (cnt_one),
      .blk_done_i   (blk_done),
      .buf_empty_i  (buf_empty),
      .start_o      (start),
      .last_start_o (last_start),
      .complete_o   (complete),
      .busy_o       (busy),
      .abort_o      (blk_abort),
      .last_o       (blk_last)
   );

   assign blk_start = start;

   assert_last_clears_rep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_start && last_start) |=> !ctl_rdata[BIT_REP]);
   assert_rsv_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctl_wr) |-> !ctl_rdata[BIT_RSV]);

endmodule

// File: tb/dma_chan_ctrl_tb_top.sv
module dma_chan_ctrl_tb_top;

   localparam int unsigned RW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ctl_wr = 1'b0;
   logic [7:0]    ctl_wdata = '0;
   logic [7:0]    ctl_rdata;
   logic          rep_wr = 1'b0;
   logic [RW-1:0] rep_wdata = '0;
   logic [RW-1:0] rep_rdata;
   logic          busy, blk_start, blk_last, blk_abort;
   logic          blk_done = 1'b0;
   logic          buf_empty = 1'b1;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   dma_chan_ctrl #(.REP_W(RW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
      .rep_wr(rep_wr), .rep_wdata(rep_wdata), .rep_rdata(rep_rdata),
      .busy(busy), .blk_start(blk_start), .blk_last(blk_last),
      .blk_done(blk_done), .buf_empty(buf_empty), .blk_abort(blk_abort)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ctl_write(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_wr = 1'b0;
   endtask

   task automatic rep_write(input logic [RW-1:0] v);
      rep_wr = 1'b1; rep_wdata = v;
      @(negedge clk);
      rep_wr = 1'b0;
   endtask

   task automatic wait_start(output bit got);
      got = 1'b0;
      for (int i = 0; i < 8; i++) begin
         if (blk_start) begin got = 1'b1; break; end
         @(negedge clk);
      end
   endtask

   // n: repeat count, rp: repeat bit, sg: single bit
   task automatic run_seq(input int n, input bit rp, input bit sg);
      int  nb;
      int  blocks;
      bit  got;
      nb = rp ? n : 1;
      blocks = 0;
      rep_write(RW'(n));
      ctl_write({1'b1, 1'b0, rp, 1'b1, 1'b0, sg, 2'b01});
      while (1) begin
         wait_start(got);
         check("R3 block start seen", 32'(got), 32'd1);
         if (!got) break;
         blocks++;
         check(rp ? "R5 last flag" : "R10 last flag", 32'(blk_last), 32'(blocks == nb));
         @(negedge clk);
         check("R5 count after start", 32'(rep_rdata), 32'((n - blocks) > 0 ? n - blocks : 0));
         check("R3 busy during block", 32'(busy), 32'd1);
         check("R3 request cleared", 32'(ctl_rdata[4]), 32'd0);
         if (blocks == nb) check("R5 repeat cleared", 32'(ctl_rdata[5]), 32'd0);
         blk_done = 1'b1;
         @(negedge clk);
         blk_done = 1'b0;
         if (blocks == nb) begin
            check("R4 idle after last", 32'(busy), 32'd0);
            check("R4 enable cleared", 32'(ctl_rdata[7]), 32'd0);
            break;
         end else if (sg) begin
            for (int k = 0; k < 3; k++) begin
               check("R7 single waits", 32'({blk_start, busy}), 32'b01);
               @(negedge clk);
            end
            ctl_write({1'b1, 1'b0, rp, 1'b1, 1'b0, 1'b1, 2'b01});
         end else begin
            check("R7 auto restart", 32'(blk_start), 32'd1);
         end
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      bit got;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset ctl", 32'(ctl_rdata), 32'd0);
      check("R1 reset count", 32'(rep_rdata), 32'd0);
      check("R1 reset outputs", 32'({busy, blk_start, blk_abort}), 32'd0);

      // every control byte written from idle
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = 8'(v);
         ctl_write(b);
         check("R1 R2 R9 readback", 32'(ctl_rdata),
               32'({b[7], b[6], b[5], b[4] & b[7], 1'b0, b[2:0]}));
         check("R3 start decision", 32'(blk_start), 32'(b[7] & b[4] & ~b[6]));
         ctl_write(8'h00);
         repeat (4) @(negedge clk);
         check("R8 R9 back to idle", 32'({ctl_rdata, busy}), 32'd0);
      end

      // repeat runs, single-shot runs, no-repeat runs
      for (int n = 1; n <= 5; n++) run_seq(n, 1'b1, 1'b0);
      for (int n = 1; n <= 3; n++) run_seq(n, 1'b1, 1'b1);
      run_seq(0, 1'b0, 1'b0);
      run_seq(3, 1'b0, 1'b0);

      // unlimited repeat, reset ignored while busy, graceful disable
      rep_write('0);
      ctl_write(8'hB0);
      for (int b = 1; b <= 6; b++) begin
         wait_start(got);
         check("R6 start seen", 32'(got), 32'd1);
         check("R6 never last", 32'(blk_last), 32'd0);
         @(negedge clk);
         check("R6 count and repeat kept", 32'({rep_rdata, ctl_rdata[5]}), 32'd1);
         if (b < 6) begin
            blk_done = 1'b1;
            @(negedge clk);
            blk_done = 1'b0;
         end
      end
      ctl_write(8'hE0);
      check("R9 reset ignored when busy", 32'({ctl_rdata[6], busy}), 32'b01);
      buf_empty = 1'b0;
      ctl_write(8'h00);
      check("R8 enable reads 0 at once", 32'({ctl_rdata[7], busy}), 32'b01);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R8 busy held while draining", 32'({busy, blk_abort}), 32'b10);
      end
      buf_empty = 1'b1;
      @(negedge clk);
      check("R8 abort pulse", 32'({busy, blk_abort}), 32'b11);
      @(negedge clk);
      check("R8 idle after abort", 32'({busy, blk_abort}), 32'b00);

      // accepted channel reset
      rep_write(RW'(7));
      ctl_write(8'h2F);
      check("R1 reserved bit dropped", 32'(ctl_rdata), 32'h27);
      ctl_write(8'h40);
      check("R9 reset bit visible", 32'(ctl_rdata[6]), 32'd1);
      ctl_write(8'h25);
      check("R9 all cleared", 32'(ctl_rdata), 32'd0);
      check("R9 count cleared", 32'(rep_rdata), 32'd0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule